// File: doc/BRIEF.md
# Channel-Blocked Tensor Layout Packer

The packer reads a four-dimensional tensor stored in planar order (batch, channel, height, width, with width varying fastest) from a word-addressed source memory. It emits the same elements as a stream in channel-blocked order: height outermost, then channel block, then width, then batch, then the channel inside the block. The block size `BLK` is a parameter and is 4 or 8. The channel count is rounded up to a whole number of blocks, and every channel slot at or above the real channel count is emitted as a zero.

A job starts with a one-cycle `start` pulse, which also samples the four dimension inputs. The block generates the source read addresses itself, waits one cycle for read data, and passes elements through a two-entry output queue. The output stream can stall on `out_ready` without losing or repeating an element. The final element carries `out_last`, and `done` pulses once the final element has been accepted. A padded slot never causes a memory read, so the read port stays idle in those cycles.

Top module: `chblk_packer`

## Requirements
- R1: Output elements follow the order height (outer), channel block, width, batch, channel within block (inner); channel index = block*BLK + slot.
- R2: A job emits exactly H * ceil(C/BLK) * W * N * BLK elements, with `out_last` high on the final one only, and no element follows it.
- R3: Every slot whose channel index is at or above C is emitted as value 0, and no memory read is issued for it.
- R4: When C is a multiple of BLK, no zero slot is inserted, and exactly N*C*H*W reads are made.
- R5: Element (n, c, h, w) with c < C is read from address ((n*C + c)*H + h)*W + w.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold steady; no element is lost or duplicated under any ready pattern.
- R7: `done` is high for exactly one cycle, the cycle after the final element's handshake, and is not high at any other point of the job.
- R8: A `start` pulse while a job is in progress is ignored.
- R9: Dimension inputs are sampled only at an accepted `start`; changing them during a job has no effect.
- R10: If any dimension is zero at `start`, `done` pulses in the next cycle with no output element and no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Job start pulse; samples the dimensions |
| dim_n | input | DIM_W | Batch count |
| dim_c | input | DIM_W | Channel count |
| dim_h | input | DIM_W | Height |
| dim_w | input | DIM_W | Width |
| rd_en | output | 1 | Source memory read strobe |
| rd_addr | output | ADDR_W | Source memory word address |
| rd_data | input | DATA_W | Read data, valid one cycle after `rd_en` |
| out_valid | output | 1 | Output element valid |
| out_ready | input | 1 | Downstream accepts the element |
| out_data | output | DATA_W | Output element |
| out_last | output | 1 | Marks the final element of the job |
| done | output | 1 | One-cycle job completion pulse |

## Verification
After an accepted `start`, the first element can be valid two clock edges later: one edge registers the read, one pushes it into the output queue. `done` is due one cycle after the final handshake, or one cycle after `start` when a dimension is zero. The bench drives inputs and samples outputs at the falling edge. It counts each handshake at the falling edge where valid and ready are both high, and checks `done` at the first falling edge after the last handshake and again at the next. Read strobes are counted at rising edges and compared with N*C*H*W once the job has ended.

// File: rtl/chblk_pkg.sv
// Package: shared types for the channel-blocked packer.
// Assumes: nothing beyond a standard SystemVerilog compiler.
package chblk_pkg;

    // Job control state of the packer.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WALK  = 2'd1,
        ST_DRAIN = 2'd2
    } pack_state_t;

endpackage

// File: rtl/chblk_addr_calc.sv
// Module: chblk_addr_calc
// Computes the planar source address ((n*C + c)*H + h)*W + w.
// Assumes: the result fits in ADDR_W bits. The value is only used for
// channel indices below C.
module chblk_addr_calc #(
    parameter int DIM_W  = 8,
    parameter int CH_W   = 9,
    parameter int ADDR_W = 16
) (
    input  logic [DIM_W-1:0]  c_q,
    input  logic [DIM_W-1:0]  h_q,
    input  logic [DIM_W-1:0]  w_q,
    input  logic [DIM_W-1:0]  n_i,
    input  logic [CH_W-1:0]   chan,
    input  logic [DIM_W-1:0]  h_i,
    input  logic [DIM_W-1:0]  w_i,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] plane;
    logic [ADDR_W-1:0] row;

    // Multiply-add chain from the batch index down to the width index.
    always_comb begin
        plane = ADDR_W'(n_i) * ADDR_W'(c_q) + ADDR_W'(chan);
        row   = plane * ADDR_W'(h_q) + ADDR_W'(h_i);
        addr  = row * ADDR_W'(w_q) + ADDR_W'(w_i);
    end

endmodule

// File: rtl/chblk_walker.sv
// Module: chblk_walker
// Holds the sampled dimensions and the five traversal counters (h, block,
// w, n, slot). Reports the current element's source address, whether it is
// a padded slot, and whether it is the final element.
// Assumes: load and advance are never high together, all sampled dimensions
// are non-zero, and BLK is a power of two.
module chblk_walker #(
    parameter int DIM_W  = 8,
    parameter int ADDR_W = 16,
    parameter int BLK    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [DIM_W-1:0]  dim_n,
    input  logic [DIM_W-1:0]  dim_c,
    input  logic [DIM_W-1:0]  dim_h,
    input  logic [DIM_W-1:0]  dim_w,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_pad,
    output logic              cur_last
);

    localparam int LG   = $clog2(BLK);
    localparam int CH_W = DIM_W + 1;
    localparam logic [LG-1:0] K_MAX = LG'(BLK - 1);

    logic [DIM_W-1:0] n_q, c_q, h_q, w_q;
    logic [CH_W-1:0]  nblk_q;
    logic [DIM_W-1:0] n_i, w_i, h_i;
    logic [CH_W-1:0]  cb_i;
    logic [LG-1:0]    k_i;
    logic [CH_W-1:0]  chan;
    logic [CH_W-1:0]  nblk_calc;
    logic             k_end, n_end, w_end, cb_end, h_end;

    assign nblk_calc = ({1'b0, dim_c} + CH_W'(BLK - 1)) >> LG;

    // Sample dimensions and the block count when a job is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q    <= '0;
            c_q    <= '0;
            h_q    <= '0;
            w_q    <= '0;
            nblk_q <= '0;
        end else if (load) begin
            n_q    <= dim_n;
            c_q    <= dim_c;
            h_q    <= dim_h;
            w_q    <= dim_w;
            nblk_q <= nblk_calc;
        end
    end

    assign k_end  = (k_i == K_MAX);
    assign n_end  = (n_i == n_q - DIM_W'(1));
    assign w_end  = (w_i == w_q - DIM_W'(1));
    assign cb_end = (cb_i == nblk_q - CH_W'(1));
    assign h_end  = (h_i == h_q - DIM_W'(1));

    // Nested counters: slot innermost, then batch, width, block, height.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            k_i  <= '0;
            n_i  <= '0;
            w_i  <= '0;
            cb_i <= '0;
            h_i  <= '0;
        end else if (advance) begin
            if (!k_end) begin
                k_i <= k_i + LG'(1);
            end else begin
                k_i <= '0;
                if (!n_end) begin
                    n_i <= n_i + DIM_W'(1);
                end else begin
                    n_i <= '0;
                    if (!w_end) begin
                        w_i <= w_i + DIM_W'(1);
                    end else begin
                        w_i <= '0;
                        if (!cb_end) begin
                            cb_i <= cb_i + CH_W'(1);
                        end else begin
                            cb_i <= '0;
                            h_i  <= h_i + DIM_W'(1);
                        end
                    end
                end
            end
        end
    end

    assign chan     = CH_W'({cb_i, k_i});
    assign cur_pad  = (chan >= {1'b0, c_q});
    assign cur_last = k_end && n_end && w_end && cb_end && h_end;

    chblk_addr_calc #(
        .DIM_W  (DIM_W),
        .CH_W   (CH_W),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .c_q  (c_q),
        .h_q  (h_q),
        .w_q  (w_q),
        .n_i  (n_i),
        .chan (chan),
        .h_i  (h_i),
        .w_i  (w_i),
        .addr (cur_addr)
    );

endmodule

// File: rtl/chblk_outq.sv
// Module: chblk_outq
// Small output queue that absorbs read data arriving while the stream
// is stalled. Head entry drives the valid/ready output.
// Assumes: the producer never pushes when full; DEPTH is a power of two >= 2.
module chblk_outq #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DATA_W-1:0]            push_data,
    input  logic                         push_last,
    input  logic                         pop,
    output logic                         head_valid,
    output logic [DATA_W-1:0]            head_data,
    output logic                         head_last,
    output logic [$clog2(DEPTH+1)-1:0]   count
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] slot_d [DEPTH];
    logic              slot_l [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;

    // Write side: store the pushed element and advance the write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                slot_d[i] <= '0;
                slot_l[i] <= 1'b0;
            end
        end else if (push) begin
            slot_d[wr_ptr] <= push_data;
            slot_l[wr_ptr] <= push_last;
            wr_ptr         <= wr_ptr + PTR_W'(1);
        end
    end

    // Read side: advance the read pointer on a handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (pop) begin
            rd_ptr <= rd_ptr + PTR_W'(1);
        end
    end

    // Occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head_valid = (count != '0);
    assign head_data  = slot_d[rd_ptr];
    assign head_last  = slot_l[rd_ptr];

endmodule

// File: rtl/chblk_packer.sv
// Module: chblk_packer (top)
// Re-orders a planar tensor from source memory into a channel-blocked
// stream with zero-filled padding slots. Job control, read issue with
// queue-space accounting, and the read-data pipeline stage live here.
// Assumes: source memory returns data exactly one cycle after rd_en;
// BLK is 4 or 8.
module chblk_packer
    import chblk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int DIM_W  = 8,
    parameter int BLK    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIM_W-1:0]  dim_n,
    input  logic [DIM_W-1:0]  dim_c,
    input  logic [DIM_W-1:0]  dim_h,
    input  logic [DIM_W-1:0]  dim_w,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              done
);

    localparam int Q_DEPTH = 2;
    localparam int CNT_W   = $clog2(Q_DEPTH + 1);

    pack_state_t       state;
    logic              dim_zero, load, issue, pop;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_pad, cur_last;
    logic              p_valid, p_pad, p_last;
    logic [CNT_W-1:0]  q_count;
    logic [CNT_W:0]    occupancy, room;

    assign dim_zero = (dim_n == '0) || (dim_c == '0) || (dim_h == '0) || (dim_w == '0);
    assign load     = (state == ST_IDLE) && start && !dim_zero;
    assign pop      = out_valid && out_ready;

    // Issue only when the queue can take the element, counting the one in flight.
    assign occupancy = {1'b0, q_count} + (CNT_W + 1)'(p_valid);
    assign room      = (CNT_W + 1)'(Q_DEPTH) + (CNT_W + 1)'(pop);
    assign issue     = (state == ST_WALK) && (occupancy < room);

    assign rd_en   = issue && !cur_pad;
    assign rd_addr = cur_addr;

    // Job control: idle, walking the tensor, draining the queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (load) state <= ST_WALK;
                ST_WALK:  if (issue && cur_last) state <= ST_DRAIN;
                ST_DRAIN: if (pop && out_last) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Pipeline stage aligned with the one-cycle memory read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_valid <= 1'b0;
            p_pad   <= 1'b0;
            p_last  <= 1'b0;
        end else begin
            p_valid <= issue;
            p_pad   <= cur_pad;
            p_last  <= cur_last;
        end
    end

    // Completion pulse: after the final handshake or a zero-size start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= ((state == ST_IDLE) && start && dim_zero) ||
                    ((state == ST_DRAIN) && pop && out_last);
        end
    end

    chblk_walker #(
        .DIM_W  (DIM_W),
        .ADDR_W (ADDR_W),
        .BLK    (BLK)
    ) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .advance  (issue),
        .dim_n    (dim_n),
        .dim_c    (dim_c),
        .dim_h    (dim_h),
        .dim_w    (dim_w),
        .cur_addr (cur_addr),
        .cur_pad  (cur_pad),
        .cur_last (cur_last)
    );

    chblk_outq #(
        .DATA_W (DATA_W),
        .DEPTH  (Q_DEPTH)
    ) u_q (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (p_valid),
        .push_data  (p_pad ? '0 : rd_data),
        .push_last  (p_last),
        .pop        (pop),
        .head_valid (out_valid),
        .head_data  (out_data),
        .head_last  (out_last),
        .count      (q_count)
    );

endmodule

// File: rtl/chblk_packer_chk.sv
// Module: chblk_packer_chk
// Property checker bound into chblk_packer. It watches the stream, the
// completion pulse and the output queue occupancy.
// Assumes: connected by the bind statement below.
module chblk_packer_chk
    import chblk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIM_W  = 8,
    parameter int CNT_W  = 2,
    parameter int DEPTH  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [DIM_W-1:0]  dim_n,
    input logic [DIM_W-1:0]  dim_c,
    input logic [DIM_W-1:0]  dim_h,
    input logic [DIM_W-1:0]  dim_w,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_last,
    input logic              done,
    input pack_state_t       state,
    input logic [CNT_W-1:0]  q_count
);

    // R6: a stalled element stays put.
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    // R6: the output queue never holds more than its depth.
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(DEPTH));

    // R7: accepting the final element raises done next cycle.
    assert_last_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> done);

    // R2: nothing is left to emit when done is high.
    assert_empty_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

    // R10: a zero dimension ends the job at once with no output.
    assert_zero_dim_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start && (state == ST_IDLE) &&
        ((dim_n == '0) || (dim_c == '0) || (dim_h == '0) || (dim_w == '0))
        |=> done && !out_valid);

endmodule

bind chblk_packer chblk_packer_chk #(
    .DATA_W (DATA_W),
    .DIM_W  (DIM_W),
    .CNT_W  (CNT_W),
    .DEPTH  (Q_DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dim_n     (dim_n),
    .dim_c     (dim_c),
    .dim_h     (dim_h),
    .dim_w     (dim_w),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .done      (done),
    .state     (state),
    .q_count   (q_count)
);

// File: tb/sim_chblk_packer.sv
// Directed bench for chblk_packer. The source memory is modelled as a
// function of the address, so no array is needed.
module sim_chblk_packer;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 16;
    localparam int DIM_W  = 8;
    localparam int BLK    = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [DIM_W-1:0]  dim_n = '0, dim_c = '0, dim_h = '0, dim_w = '0;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data = '0;
    logic              out_valid, out_ready = 1'b0, out_last, done;
    logic [DATA_W-1:0] out_data;

    int tests = 0;
    int fails = 0;
    int rd_count = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [DATA_W-1:0] exp_d [512];
    logic              exp_l [512];
    int                exp_n;
    int                exp_pads;

    always #5 clk = ~clk;

    chblk_packer #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .DIM_W  (DIM_W),
        .BLK    (BLK)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dim_n     (dim_n),
        .dim_c     (dim_c),
        .dim_h     (dim_h),
        .dim_w     (dim_w),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last),
        .done      (done)
    );

    function automatic logic [DATA_W-1:0] mem_val(input logic [ADDR_W-1:0] a);
        return a ^ 16'h5A00;
    endfunction

    // Source memory with one-cycle read latency, plus a read counter.
    always @(posedge clk) begin
        if (rd_en) begin
            rd_data  <= mem_val(rd_addr);
            rd_count <= rd_count + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference order: h, block, w, n, slot; zero for channel >= C.
    task automatic build_expected(input int n, input int c, input int h, input int w);
        int nb;
        nb = (c + BLK - 1) / BLK;
        exp_n = 0;
        exp_pads = 0;
        for (int hi = 0; hi < h; hi++)
            for (int bi = 0; bi < nb; bi++)
                for (int wi = 0; wi < w; wi++)
                    for (int ni = 0; ni < n; ni++)
                        for (int k = 0; k < BLK; k++) begin
                            int ch;
                            ch = bi * BLK + k;
                            if (ch < c) begin
                                exp_d[exp_n] = mem_val(ADDR_W'(((ni * c + ch) * h + hi) * w + wi));
                            end else begin
                                exp_d[exp_n] = '0;
                                exp_pads++;
                            end
                            exp_l[exp_n] = 1'b0;
                            exp_n++;
                        end
        exp_l[exp_n - 1] = 1'b1;
    endtask

    task automatic pulse_start(input int n, input int c, input int h, input int w, input bit scramble);
        @(negedge clk);
        dim_n = DIM_W'(n);
        dim_c = DIM_W'(c);
        dim_h = DIM_W'(h);
        dim_w = DIM_W'(w);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin
            dim_n = 8'd3;
            dim_c = 8'd7;
            dim_h = 8'd1;
            dim_w = 8'd5;
        end
    endtask

    function automatic logic ready_pick(input int mode, input int cyc, input logic bit0);
        case (mode)
            0:       return 1'b1;
            1:       return (cyc % 3) != 0;
            default: return bit0;
        endcase
    endfunction

    // One full job: stream compare, stall hold, done timing, read count.
    task automatic run_job(input int n, input int c, input int h, input int w,
                           input int mode, input bit poke, input string name);
        int idx, cyc, early_done, zeros, reads0;
        bit prev_stall;
        logic [DATA_W-1:0] prev_d;
        logic prev_l;
        build_expected(n, c, h, w);
        reads0 = rd_count;
        idx = 0; cyc = 0; early_done = 0; zeros = 0;
        prev_stall = 1'b0; prev_d = '0; prev_l = 1'b0;
        pulse_start(n, c, h, w, poke);
        while (idx < exp_n && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (poke && cyc == 4) start = 1'b1;
            if (poke && cyc == 5) start = 1'b0;
            out_ready = ready_pick(mode, cyc, lfsr[0]);
            if (done) early_done++;
            if (prev_stall) begin
                check(out_valid && out_data == prev_d && out_last == prev_l,
                      {name, " R6 stall hold"}, int'(out_data), int'(prev_d));
            end
            if (out_valid && out_ready) begin
                check(out_data == exp_d[idx], {name, " R1 R5 element"},
                      int'(out_data), int'(exp_d[idx]));
                check(out_last == exp_l[idx], {name, " R2 last flag"},
                      int'(out_last), int'(exp_l[idx]));
                if (out_data == '0) zeros++;
                idx++;
            end
            prev_stall = out_valid && !out_ready;
            prev_d = out_data;
            prev_l = out_last;
        end
        check(idx == exp_n, {name, " R2 element count"}, idx, exp_n);
        @(negedge clk);
        out_ready = 1'b1;
        check(done == 1'b1, {name, " R7 done after last"}, int'(done), 1);
        check(out_valid == 1'b0, {name, " R2 nothing after last"}, int'(out_valid), 0);
        @(negedge clk);
        check(done == 1'b0, {name, " R7 done one cycle"}, int'(done), 0);
        check(early_done == 0, {name, " R7 R8 no early done"}, early_done, 0);
        check(zeros == exp_pads, {name, " R3 R4 zero slots"}, zeros, exp_pads);
        check(rd_count - reads0 == n * c * h * w, {name, " R3 R4 read count"},
              rd_count - reads0, n * c * h * w);
    endtask

    task automatic run_zero(input int n, input int c, input int h, input int w, input string name);
        int reads0;
        reads0 = rd_count;
        pulse_start(n, c, h, w, 1'b0);
        check(done == 1'b1, {name, " R10 done next cycle"}, int'(done), 1);
        check(out_valid == 1'b0, {name, " R10 no output"}, int'(out_valid), 0);
        @(negedge clk);
        check(done == 1'b0, {name, " R10 done single"}, int'(done), 0);
        check(out_valid == 1'b0 && rd_count == reads0, {name, " R10 no reads"},
              rd_count - reads0, 0);
    endtask

    task automatic check_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "reset out_valid", int'(out_valid), 0);
        check(done == 1'b0, "reset done", int'(done), 0);
        check(rd_en == 1'b0, "reset rd_en", int'(rd_en), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check_reset();
        run_job(1, 3, 2, 2, 0, 1'b0, "rgb");            // R1 R3 one pad per pixel
        run_job(1, 8, 2, 2, 1, 1'b0, "exact8");         // R4 two full blocks
        run_job(2, 5, 2, 3, 2, 1'b0, "c5n2");           // R1 R2 R6 block order with batch
        run_zero(1, 0, 2, 2, "zeroC");                  // R10
        run_zero(2, 3, 0, 2, "zeroH");                  // R10
        run_job(1, 1, 1, 1, 0, 1'b0, "single");         // R2 R3 smallest job
        run_job(2, 3, 2, 2, 1, 1'b1, "poke");           // R8 R9 start and dims changed mid-job
        run_job(1, 4, 1, 3, 2, 1'b0, "exact4");         // R4 R6
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got %0d expected %0d", 150000, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule